// File: doc/BRIEF.md
# Multi-mode PWM timer

This block is a pulse-width modulation timer built around one up/down counter. A programmable clock-enable divider slows the counter down. The counter runs in one of three counting modes:

- **Fast mode:** the counter runs single-slope, from zero up to a TOP value, and then wraps.
- **Phase-correct mode:** the counter runs dual-slope, up to TOP and back down to zero.
- **Phase-and-frequency-correct mode:** also dual-slope, but a new period value is held back until the counter reaches its bottom.

The single output is high while the counter is below the active compare value. A one-cycle period pulse marks every period boundary, so the surrounding logic can load the next duty value in step with the waveform.

Software-side logic drives the block through a small write port with three registers:

| Address | Register | Fields |
|---|---|---|
| 0 | Control | bits [1:0] counting mode; bits [3:2] TOP source; bits [6:4] divider |
| 1 | Compare value | 16 bits |
| 2 | Period value | 16 bits |

Encodings:

- **Counting mode:** 0 off, 1 fast, 2 phase-correct, 3 phase-and-frequency-correct.
- **TOP source:** 0 fixed 0x00FF, 1 fixed 0x01FF, 2 fixed 0x03FF, 3 the period register.

Writing the control register restarts the counter at zero, counting up, and loads the active compare and period copies from the written values.

The counter is a state machine with three states:

- **`ST_HALT`:** the mode is off.
- **`ST_UP`:** counting upward.
- **`ST_DOWN`:** counting downward.

Its transitions are:

- **any → `ST_HALT`:** the mode is off.
- **`ST_HALT` → `ST_UP`:** a mode is selected.
- **any → `ST_UP` (restart):** a control write while running.
- **`ST_UP` → `ST_UP` (wrap):** fast mode, at TOP, the counter wraps to zero.
- **`ST_UP` → `ST_DOWN` (turn):** a dual-slope mode reaches TOP.
- **`ST_DOWN` → `ST_UP` (bottom):** the count reaches zero.

Top module: `pwm_timer`

## Requirements
- R1: After reset the mode is off. While the mode is off, `pwm_out` stays 0 and `ovf_pulse` never rises, even if compare writes occur.
- R2: In fast mode (mode code 1) one period lasts P × (TOP + 1) clock cycles, where P is the divider ratio.
- R3: In both dual-slope modes (codes 2 and 3) one period lasts P × 2 × TOP clock cycles. An 8-bit TOP of 0xFF at P = 1 gives 510 cycles.
- R4: For 0 < compare < TOP the output is high for P × compare cycles per period in fast mode, and for P × (2 × compare − 1) cycles per period in the dual-slope modes.
- R5: A compare value of 0 keeps the output low for the whole period.
- R6: A compare value equal to or above TOP keeps the output high for the whole period, while the period pulses continue.
- R7: TOP source code 0 selects 0x00FF, code 1 selects 0x01FF, code 2 selects 0x03FF, and code 3 selects the period register (address 2).
- R8: Divider code 0 gives ÷1, code 1 gives ÷8, code 2 gives ÷64, code 3 gives ÷256, and codes 4 to 7 give ÷1024. Counter steps are never closer together than the selected ratio.
- R9: `ovf_pulse` is high for one cycle per period. It is high in the first cycle in which the counter reads zero after the fast-mode wrap or after the dual-slope descent.
- R10: A compare write in the middle of a period leaves that period unchanged. The new value takes effect from the next period boundary.
- R11: In phase-and-frequency-correct mode, a period-register write in the middle of a period leaves that period unchanged. The new TOP takes effect at the next bottom.
- R12: Writes to address 3 have no effect. Only a write to address 0 restarts the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 compare, 2 period |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | Modulated output, high while the counter is below the compare value |
| ovf_pulse | output | 1 | One-cycle pulse at each period boundary |

## Verification
The waveform is measured period by period, from one period pulse to the next, as a pair of period length and high time.

Settings are chosen to separate single-slope from dual-slope counting:

- **TOP sources:** each of the three fixed TOP values and the period register.
- **Divider codes:** each divider code.
- **Compare values:** zero, compare values in range, and values at or above TOP, which separate the two saturated cases from the linear duty law.

Updates are also written in the middle of a period, and the pairs that follow tell buffered updates from immediate ones:

- **Compare update:** checks that the compare value is buffered.
- **Period update in phase-and-frequency-correct mode:** checks that TOP is held back until the bottom.
- **Write to the unused address:** must leave the period sequence unchanged.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_FAST  = 2'd1,
        MODE_PHASE = 2'd2,
        MODE_PFC   = 2'd3
    } pwm_mode_e;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } cnt_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CMP  = 2'd1;
    localparam logic [1:0] ADDR_PER  = 2'd2;

    localparam logic [1:0] TSEL_8B  = 2'd0;
    localparam logic [1:0] TSEL_9B  = 2'd1;
    localparam logic [1:0] TSEL_10B = 2'd2;
    localparam logic [1:0] TSEL_REG = 2'd3;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       tick
);

    localparam logic [PRE_W-1:0] LIM_1    = PRE_W'(0);
    localparam logic [PRE_W-1:0] LIM_8    = PRE_W'(7);
    localparam logic [PRE_W-1:0] LIM_64   = PRE_W'(63);
    localparam logic [PRE_W-1:0] LIM_256  = PRE_W'(255);
    localparam logic [PRE_W-1:0] LIM_1024 = PRE_W'(1023);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit;

    always_comb begin
        unique case (sel)
            3'd0:    limit = LIM_1;
            3'd1:    limit = LIM_8;
            3'd2:    limit = LIM_64;
            3'd3:    limit = LIM_256;
            default: limit = LIM_1024;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (!run || (pre_cnt >= limit)) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end

    assign tick = run && (pre_cnt >= limit);

    AST_PRESCALE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel != 3'd0) |=> (!tick || sel == 3'd0)); // R8

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             load_act,
    output pwm_mode_e        mode,
    output logic [1:0]       top_sel,
    output logic [2:0]       pre_sel,
    output logic [CNT_W-1:0] cmp_act,
    output logic [CNT_W-1:0] per_sh,
    output logic [CNT_W-1:0] per_act,
    output logic             restart
);

    logic [CNT_W-1:0] cmp_sh;

    assign restart = wr_en && (wr_addr == ADDR_CTRL);

    // control fields and shadow copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode    <= MODE_OFF;
            top_sel <= TSEL_8B;
            pre_sel <= 3'd0;
            cmp_sh  <= '0;
            per_sh  <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTRL: begin
                    mode    <= pwm_mode_e'(wr_data[1:0]);
                    top_sel <= wr_data[3:2];
                    pre_sel <= wr_data[6:4];
                end
                ADDR_CMP: cmp_sh <= wr_data;
                ADDR_PER: per_sh <= wr_data;
                default: ;
            endcase
        end
    end

    // active copies: loaded at a restart or a period boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_act <= '0;
            per_act <= '0;
        end else if (restart || load_act) begin
            cmp_act <= cmp_sh;
            per_act <= per_sh;
        end
    end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pwm_mode_e        mode,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] cnt,
    output cnt_state_e       state,
    output logic             evt,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e       st_n;
    logic [CNT_W-1:0] cnt_n;
    logic             dual;
    logic             at_top;

    assign dual   = (mode == MODE_PHASE) || (mode == MODE_PFC);
    assign at_top = (cnt >= top);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HALT;
            cnt   <= '0;
            ovf   <= 1'b0;
        end else begin
            state <= st_n;
            cnt   <= cnt_n;
            ovf   <= evt;
        end
    end

    // next state and count
    always_comb begin
        st_n  = state;
        cnt_n = cnt;
        if (mode == MODE_OFF) begin
            st_n  = ST_HALT;
            cnt_n = '0;
        end else if (restart) begin
            st_n  = ST_UP;
            cnt_n = '0;
        end else begin
            unique case (state)
                ST_HALT: begin
                    st_n  = ST_UP;
                    cnt_n = '0;
                end
                ST_UP: begin
                    if (tick) begin
                        if (at_top) begin
                            if (!dual || top == '0) begin
                                cnt_n = '0;
                            end else begin
                                cnt_n = top - ONE;
                                st_n  = (top == ONE) ? ST_UP : ST_DOWN;
                            end
                        end else begin
                            cnt_n = cnt + ONE;
                        end
                    end
                end
                ST_DOWN: begin
                    if (tick) begin
                        if (cnt <= ONE) begin
                            cnt_n = '0;
                            st_n  = ST_UP;
                        end else begin
                            cnt_n = cnt - ONE;
                        end
                    end
                end
                default: begin
                    st_n  = ST_HALT;
                    cnt_n = '0;
                end
            endcase
        end
    end

    // period boundary event: fast wrap or dual-slope bottom
    always_comb begin
        evt = 1'b0;
        if (tick) begin
            if (state == ST_UP && at_top) begin
                evt = (mode == MODE_FAST) || (dual && top == ONE);
            end else if (state == ST_DOWN && cnt <= ONE) begin
                evt = 1'b1;
            end
        end
    end

    AST_SINGLE_SLOPE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DOWN) |-> dual); // R2

    AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (cnt == '0)); // R9

    AST_OFF_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |=> (state == ST_HALT && !ovf)); // R1

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int CNT_W = 16
) (
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] top,
    output logic             pwm
);

    logic saturated;
    logic below;

    assign saturated = (cmp >= top);
    assign below     = (cnt < cmp);
    assign pwm       = run && (cmp != '0) && (saturated || below);

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out,
    output logic             ovf_pulse
);

    localparam logic [CNT_W-1:0] TOP_8B  = CNT_W'(16'h00FF);
    localparam logic [CNT_W-1:0] TOP_9B  = CNT_W'(16'h01FF);
    localparam logic [CNT_W-1:0] TOP_10B = CNT_W'(16'h03FF);

    pwm_mode_e        mode;
    logic [1:0]       top_sel;
    logic [2:0]       pre_sel;
    logic [CNT_W-1:0] cmp_act;
    logic [CNT_W-1:0] per_sh;
    logic [CNT_W-1:0] per_act;
    logic             restart;
    logic             tick;
    logic             evt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] top_eff;
    cnt_state_e       state;
    logic             run_pre;

    assign run_pre = (mode != MODE_OFF) && !restart;

    pwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .load_act (evt),
        .mode     (mode),
        .top_sel  (top_sel),
        .pre_sel  (pre_sel),
        .cmp_act  (cmp_act),
        .per_sh   (per_sh),
        .per_act  (per_act),
        .restart  (restart)
    );

    pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_pre),
        .sel   (pre_sel),
        .tick  (tick)
    );

    // TOP resolution: buffered period only in phase-and-frequency-correct mode
    always_comb begin
        unique case (top_sel)
            TSEL_8B:  top_eff = TOP_8B;
            TSEL_9B:  top_eff = TOP_9B;
            TSEL_10B: top_eff = TOP_10B;
            default:  top_eff = (mode == MODE_PFC) ? per_act : per_sh;
        endcase
    end

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .restart (restart),
        .tick    (tick),
        .top     (top_eff),
        .cnt     (cnt),
        .state   (state),
        .evt     (evt),
        .ovf     (ovf_pulse)
    );

    pwm_compare #(.CNT_W(CNT_W)) u_cmp (
        .run (state != ST_HALT),
        .cnt (cnt),
        .cmp (cmp_act),
        .top (top_eff),
        .pwm (pwm_out)
    );

    AST_HALT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> !pwm_out); // R1

    AST_CMP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmp_act) |-> (cnt == '0)); // R10

    AST_PFC_TOP_AT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PFC && !$stable(top_eff)) |-> (cnt == '0)); // R11

    AST_PFC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PFC && state != ST_HALT) |-> (cnt <= top_eff)); // R11

endmodule

// File: tb/test_pwm_timer.sv
`timescale 1ns/1ps
module test_pwm_timer;

    localparam int CW = 16;

    logic          clk     = 1'b0;
    logic          rst_n   = 1'b0;
    logic          wr_en   = 1'b0;
    logic [1:0]    wr_addr = 2'd0;
    logic [CW-1:0] wr_data = '0;
    logic          pwm_out;
    logic          ovf_pulse;

    always #2.5 clk = ~clk;

    pwm_timer #(.CNT_W(CW), .PRE_W(10)) i_pwm_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pwm_out   (pwm_out),
        .ovf_pulse (ovf_pulse)
    );

    typedef struct {
        int    per;
        int    hi;
        string req_p;
        string req_h;
    } exp_t;

    exp_t sb_q[$];
    int   checks   = 0;
    int   failures = 0;
    bit   done     = 1'b0;
    int   cyc      = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic [CW-1:0] ctrl(input int m, input int ts, input int ps);
        return {9'd0, 3'(ps), 2'(ts), 2'(m)};
    endfunction

    task automatic wait_ovf(input int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (!ovf_pulse);
        end
    endtask

    task automatic push(input int per, input int hi, input string rp, input string rh);
        exp_t e;
        e.per = per; e.hi = hi; e.req_p = rp; e.req_h = rh;
        sb_q.push_back(e);
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic run_case(input int m, input int ts, input int ps, input int cmp,
                            input int per, input int exp_per, input int exp_hi,
                            input string rp, input string rh);
        reg_wr(2'd1, CW'(cmp));
        reg_wr(2'd2, CW'(per));
        reg_wr(2'd0, ctrl(m, ts, ps));
        wait_ovf(2);
        @(negedge clk);
        push(exp_per, exp_hi, rp, rh);
        push(exp_per, exp_hi, rp, rh);
        drain();
    endtask

    // monitor: measures each window between period pulses
    int m_per   = 0;
    int m_hi    = 0;
    bit m_valid = 1'b0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ovf_pulse) begin
                if (m_valid && sb_q.size() > 0) begin : cmp_blk
                    exp_t e;
                    e = sb_q.pop_front();
                    check(m_per == e.per, e.req_p, "period", m_per, e.per);
                    check(m_hi == e.hi, e.req_h, "high_time", m_hi, e.hi);
                end
                m_valid = 1'b1;
                m_per   = 1;
                m_hi    = int'(pwm_out);
            end else begin
                m_per++;
                m_hi += int'(pwm_out);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        int seen;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(pwm_out == 1'b0, "R1", "pwm_in_reset", int'(pwm_out), 0);
        check(ovf_pulse == 1'b0, "R1", "ovf_in_reset", int'(ovf_pulse), 0);
        rst_n = 1'b1;
        reg_wr(2'd1, CW'(10));
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            seen += int'(ovf_pulse) + int'(pwm_out);
        end
        check(seen == 0, "R1", "activity_while_off", seen, 0);

        // R2 R4 R7: fast, fixed 8-bit TOP
        run_case(1, 0, 0, 64, 0, 256, 64, "R2", "R4");
        // R7: fixed 9-bit TOP, fast
        run_case(1, 1, 0, 256, 0, 512, 256, "R7", "R4");
        // R3: phase-correct, 8-bit TOP -> 510 cycles
        run_case(2, 0, 0, 100, 0, 510, 199, "R3", "R4");
        // R7: fixed 10-bit TOP, dual slope
        run_case(2, 2, 0, 512, 0, 2046, 1023, "R7", "R4");
        // R8: dividers on register TOP
        run_case(1, 3, 1, 30, 99, 800, 240, "R8", "R4");
        run_case(1, 3, 2, 5, 9, 640, 320, "R8", "R4");
        run_case(1, 3, 3, 2, 3, 1024, 512, "R8", "R4");
        run_case(1, 3, 4, 2, 3, 4096, 2048, "R8", "R4");
        // R5: compare zero
        run_case(1, 3, 0, 0, 40, 41, 0, "R2", "R5");
        run_case(3, 3, 0, 0, 50, 100, 0, "R3", "R5");
        // R6: compare at or above TOP
        run_case(1, 3, 0, 40, 40, 41, 41, "R2", "R6");
        run_case(3, 3, 0, 60, 50, 100, 100, "R9", "R6");
        // R3 R4: phase-and-frequency-correct, in-range compare
        run_case(3, 3, 0, 20, 50, 100, 39, "R3", "R4");

        // R10: compare written mid-period in fast mode
        run_case(1, 3, 0, 30, 99, 100, 30, "R2", "R4");
        wait_ovf(1);
        @(negedge clk);
        push(100, 30, "R10", "R10");
        push(100, 70, "R10", "R10");
        repeat (10) @(negedge clk);
        reg_wr(2'd1, CW'(70));
        drain();

        // R11: period written mid-period in PFC mode
        run_case(3, 3, 0, 20, 50, 100, 39, "R3", "R4");
        wait_ovf(1);
        @(negedge clk);
        push(100, 39, "R11", "R11");
        push(160, 39, "R11", "R11");
        repeat (10) @(negedge clk);
        reg_wr(2'd2, CW'(80));
        drain();

        // R12: unused address ignored, no restart
        wait_ovf(1);
        @(negedge clk);
        push(160, 39, "R12", "R12");
        push(160, 39, "R12", "R12");
        repeat (10) @(negedge clk);
        reg_wr(2'd3, CW'(16'h0003));
        drain();

        // R1: switching off stops everything
        reg_wr(2'd0, ctrl(0, 3, 0));
        repeat (2) @(negedge clk);
        seen = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            seen += int'(ovf_pulse) + int'(pwm_out);
        end
        check(seen == 0, "R1", "activity_after_off", seen, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule